// File: doc/BRIEF.md
# Dual-Width 8B/10B Receive Decoder

This block turns aligned 8B/10B code groups back into bytes on the receive path. A configuration pin sets the width. In single-width operation one 10-bit code group arrives per clock. In double-width operation a 20-bit word carries two code groups, and both are decoded in the same clock by two chained decoder slices. The running disparity that the first slice ends with is the starting disparity of the second. A register holds the running disparity from one accepted word to the next.

Each byte lane reports its own decoded byte and three flags. The control flag marks one of the twelve standard special characters. The code-error flag marks a pattern that is not a legal code group. The disparity-error flag marks a legal code group that arrived with the wrong running disparity. After a disparity error the decoder takes the running disparity implied by the received pattern, so it falls back into step by itself. Results appear one registered cycle after the input.

Top module: `dw_8b10b_decoder`

## Requirements
- R1: During and after reset `out_vld`, `data_out`, `ctl_out`, `code_err` and `disp_err` are all zero, and the running disparity starts negative. The first code group after reset is therefore checked against the negative-disparity encodings.
- R2: `out_vld` is high exactly one cycle after a cycle with `in_vld` high, and is low otherwise. The outputs and the running disparity change only in the cycle after `in_vld` is high.
- R3: A lane's code group uses bit 0 for the first transmitted bit a, then b, c, d, e, i, f, g, h, with j in bit 9. The decoded byte has bits [4:0] = EDCBA and bits [7:5] = HGF. For example, 10'h17C decodes to 8'hBC with the control flag set.
- R4: With `wide_mode` low, only `code_in[9:0]` is decoded. `data_out[15:8]`, `ctl_out[1]`, `code_err[1]` and `disp_err[1]` read zero.
- R5: With `wide_mode` high, `code_in[9:0]` decodes into lane 0 (`data_out[7:0]`, bit 0 of each flag vector) and `code_in[19:10]` decodes into lane 1 (`data_out[15:8]`, bit 1 of each flag vector).
- R6: In double-width operation, lane 1 is checked against the ending running disparity of lane 0 from the same word.
- R7: The running disparity carried to the next accepted word is the ending disparity of the last lane in use: lane 1 in double-width operation, lane 0 otherwise.
- R8: The control flag is set for K28.0 to K28.7, K23.7, K27.7, K29.7 and K30.7 (bytes 8'h1C + 32*y, 8'hF7, 8'hFB, 8'hFD, 8'hFE). It is clear for every data character and for every flagged code group.
- R9: A pattern that matches no legal code group at either disparity sets that lane's code-error flag. For that lane the disparity-error and control flags are clear and the data reads zero, and the running disparity passes through unchanged.
- R10: A legal code group that matches only the opposite running disparity sets the disparity-error flag and still returns the correct byte and control flag. The running disparity continues from the disparity that pattern ends with.
- R11: Errors in one lane do not disturb the data or flags of the other lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wide_mode | input | 1 | 1 = two code groups per word, 0 = one code group |
| in_vld | input | 1 | Input word is valid this cycle |
| code_in | input | 20 | Code groups; lane 0 in [9:0], lane 1 in [19:10] |
| out_vld | output | 1 | Decoded results valid |
| data_out | output | 16 | Decoded bytes; lane 0 in [7:0], lane 1 in [15:8] |
| ctl_out | output | 2 | Per-lane control-character flag |
| code_err | output | 2 | Per-lane invalid-code flag |
| disp_err | output | 2 | Per-lane running-disparity error flag |

## Verification
A disparity error in one lane and a correct decode in the other lane can fall in the same word. So can a disparity change produced by lane 0 and a check of lane 1 against that change. The bench provokes both by building 20-bit words from a separate reference encoder. It encodes lane 1 either with the disparity lane 0 leaves behind, or on purpose with the disparity from before the word. It then judges each lane's byte and flags on its own, and checks the running disparity carried on by encoding the next word from its model and expecting no error.

// File: rtl/dwd_pkg.sv
package dwd_pkg;

  localparam int SYM_W  = 10;
  localparam int BYTE_W = 8;

  typedef struct packed {
    logic [BYTE_W-1:0] data;
    logic              ctl;
    logic              cerr;
    logic              derr;
  } lane_res_t;

  // 6-bit sub-block for negative disparity, first transmitted bit at [5]
  function automatic logic [5:0] six_neg(input logic [4:0] x);
    case (x)
      5'd0:  six_neg = 6'b100111;  5'd1:  six_neg = 6'b011101;
      5'd2:  six_neg = 6'b101101;  5'd3:  six_neg = 6'b110001;
      5'd4:  six_neg = 6'b110101;  5'd5:  six_neg = 6'b101001;
      5'd6:  six_neg = 6'b011001;  5'd7:  six_neg = 6'b111000;
      5'd8:  six_neg = 6'b111001;  5'd9:  six_neg = 6'b100101;
      5'd10: six_neg = 6'b010101;  5'd11: six_neg = 6'b110100;
      5'd12: six_neg = 6'b001101;  5'd13: six_neg = 6'b101100;
      5'd14: six_neg = 6'b011100;  5'd15: six_neg = 6'b010111;
      5'd16: six_neg = 6'b011011;  5'd17: six_neg = 6'b100011;
      5'd18: six_neg = 6'b010011;  5'd19: six_neg = 6'b110010;
      5'd20: six_neg = 6'b001011;  5'd21: six_neg = 6'b101010;
      5'd22: six_neg = 6'b011010;  5'd23: six_neg = 6'b111010;
      5'd24: six_neg = 6'b110011;  5'd25: six_neg = 6'b100110;
      5'd26: six_neg = 6'b010110;  5'd27: six_neg = 6'b110110;
      5'd28: six_neg = 6'b001110;  5'd29: six_neg = 6'b101110;
      5'd30: six_neg = 6'b011110;  default: six_neg = 6'b101011;
    endcase
  endfunction

  function automatic logic [3:0] four_neg(input logic [2:0] y, input logic special);
    if (special) begin
      case (y)
        3'd0: four_neg = 4'b1011; 3'd1: four_neg = 4'b0110;
        3'd2: four_neg = 4'b1010; 3'd3: four_neg = 4'b1100;
        3'd4: four_neg = 4'b1101; 3'd5: four_neg = 4'b0101;
        3'd6: four_neg = 4'b1001; default: four_neg = 4'b0111;
      endcase
    end else begin
      case (y)
        3'd0: four_neg = 4'b1011; 3'd1: four_neg = 4'b1001;
        3'd2: four_neg = 4'b0101; 3'd3: four_neg = 4'b1100;
        3'd4: four_neg = 4'b1101; 3'd5: four_neg = 4'b1010;
        3'd6: four_neg = 4'b0110; default: four_neg = 4'b1110;
      endcase
    end
  endfunction

  function automatic logic k_legal(input logic [7:0] d);
    k_legal = (d[4:0] == 5'd28) || (d == 8'hF7) || (d == 8'hFB) ||
              (d == 8'hFD) || (d == 8'hFE);
  endfunction

  // returns {ending disparity, code[9:0]}, code bit 0 = first transmitted bit
  function automatic logic [SYM_W:0] encode(input logic [7:0] d, input logic k,
                                            input logic rd);
    logic [5:0] s6;
    logic [3:0] f4;
    logic       rdm, alt;
    logic [9:0] t;
    logic [9:0] c;
    s6 = (k && d[4:0] == 5'd28) ? 6'b001111 : six_neg(d[4:0]);
    if (rd && (($countones(s6) != 3) || (s6 == 6'b111000))) s6 = ~s6;
    rdm = ($countones(s6) != 3) ? ~rd : rd;
    if (k) begin
      f4 = (d[4:0] == 5'd28) ? four_neg(d[7:5], 1'b1) : 4'b0111;
      if (rdm) f4 = ~f4;
    end else begin
      alt = (d[7:5] == 3'd7) &&
            ((!rdm && (d[4:0] == 5'd17 || d[4:0] == 5'd18 || d[4:0] == 5'd20)) ||
             ( rdm && (d[4:0] == 5'd11 || d[4:0] == 5'd13 || d[4:0] == 5'd14)));
      f4 = alt ? 4'b0111 : four_neg(d[7:5], 1'b0);
      if (rdm && (($countones(f4) != 2) || (f4 == 4'b1100))) f4 = ~f4;
    end
    t = {s6, f4};
    for (int j = 0; j < SYM_W; j++) c[j] = t[SYM_W-1-j];
    encode = {(($countones(f4) != 2) ? ~rdm : rdm), c};
  endfunction

endpackage

// File: rtl/dwd_slice.sv
module dwd_slice
  import dwd_pkg::*;
(
  input  logic [SYM_W-1:0] code,
  input  logic             rd_in,
  output lane_res_t        res,
  output logic             rd_out
);

  localparam int CAND = 2 ** (BYTE_W + 1);

  logic            hit_same, hit_opp;
  logic [BYTE_W:0] sym_same, sym_opp;
  logic            end_same, end_opp;

  always_comb begin
    hit_same = 1'b0;
    hit_opp  = 1'b0;
    sym_same = '0;
    sym_opp  = '0;
    end_same = rd_in;
    end_opp  = rd_in;
    for (int i = 0; i < CAND; i++) begin
      logic [BYTE_W:0] s;
      logic [SYM_W:0]  es, eo;
      s  = (BYTE_W+1)'(i);
      es = encode(s[BYTE_W-1:0], s[BYTE_W], rd_in);
      eo = encode(s[BYTE_W-1:0], s[BYTE_W], ~rd_in);
      if (!s[BYTE_W] || k_legal(s[BYTE_W-1:0])) begin
        if (!hit_same && es[SYM_W-1:0] == code) begin
          hit_same = 1'b1;
          sym_same = s;
          end_same = es[SYM_W];
        end
        if (!hit_opp && eo[SYM_W-1:0] == code) begin
          hit_opp = 1'b1;
          sym_opp = s;
          end_opp = eo[SYM_W];
        end
      end
    end
  end

  always_comb begin
    res    = '0;
    rd_out = rd_in;
    if (hit_same) begin
      res.data = sym_same[BYTE_W-1:0];
      res.ctl  = sym_same[BYTE_W];
      rd_out   = end_same;
    end else if (hit_opp) begin
      res.data = sym_opp[BYTE_W-1:0];
      res.ctl  = sym_opp[BYTE_W];
      res.derr = 1'b1;
      rd_out   = end_opp;
    end else begin
      res.cerr = 1'b1;
    end
  end

endmodule

// File: rtl/dwd_out_stage.sv
module dwd_out_stage
  import dwd_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en,
  input  lane_res_t [LANES-1:0] d,
  output logic                  vld_q,
  output lane_res_t [LANES-1:0] q
);

  lane_res_t [LANES-1:0] q_d;
  logic                  vld_d;

  always_comb begin
    vld_d = en;
    q_d   = en ? d : q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      q     <= '0;
    end else begin
      vld_q <= vld_d;
      q     <= q_d;
    end
  end

endmodule

// File: rtl/dw_8b10b_decoder.sv
module dw_8b10b_decoder
  import dwd_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wide_mode,
  input  logic                    in_vld,
  input  logic [LANES*SYM_W-1:0]  code_in,
  output logic                    out_vld,
  output logic [LANES*BYTE_W-1:0] data_out,
  output logic [LANES-1:0]        ctl_out,
  output logic [LANES-1:0]        code_err,
  output logic [LANES-1:0]        disp_err
);

  logic                  rd_q, rd_d;
  logic [LANES:0]        rd_chain;
  lane_res_t [LANES-1:0] res_raw, res_m, res_q;

  assign rd_chain[0] = rd_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    dwd_slice u_slice (
      .code   (code_in[g*SYM_W +: SYM_W]),
      .rd_in  (rd_chain[g]),
      .res    (res_raw[g]),
      .rd_out (rd_chain[g+1])
    );
    if (g == 0) begin : g_first
      assign res_m[g] = res_raw[g];
    end else begin : g_upper
      assign res_m[g] = wide_mode ? res_raw[g] : '0;
    end
    assign data_out[g*BYTE_W +: BYTE_W] = res_q[g].data;
    assign ctl_out[g]  = res_q[g].ctl;
    assign code_err[g] = res_q[g].cerr;
    assign disp_err[g] = res_q[g].derr;
  end

  // running disparity: 0 = negative, 1 = positive
  always_comb begin
    rd_d = rd_q;
    if (in_vld) rd_d = wide_mode ? rd_chain[LANES] : rd_chain[1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= 1'b0;
    else        rd_q <= rd_d;
  end

  dwd_out_stage #(.LANES(LANES)) u_out (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (in_vld),
    .d     (res_m),
    .vld_q (out_vld),
    .q     (res_q)
  );

  // R2: one-cycle latency of the valid strobe
  a_r2_vld_latency: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> out_vld);
  a_r2_vld_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> !out_vld);
  // R7: running disparity only moves on accepted words
  a_r7_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> $stable(rd_q));
  // R4: upper lane quiet in single-width operation
  a_r4_upper_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && !wide_mode) |=> (data_out[2*BYTE_W-1:BYTE_W] == '0 &&
                                !ctl_out[1] && !code_err[1] && !disp_err[1]));
  // R9: a lane never reports both error kinds, nor control with code error
  a_r9_err_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> ((code_err & disp_err) == '0 && (ctl_out & code_err) == '0));
  // R8: control flag only on special-character byte values
  a_r8_ctl_values: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && ctl_out[0]) |-> (data_out[4:0] == 5'd28 || data_out[7:5] == 3'd7));

endmodule

// File: tb/tb_dw_8b10b_decoder.sv
`timescale 1ns/1ps
module tb_dw_8b10b_decoder;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wide_mode;
  logic        in_vld;
  logic [19:0] code_in;
  logic        out_vld;
  logic [15:0] data_out;
  logic [1:0]  ctl_out, code_err, disp_err;

  int total = 0;
  int bad   = 0;
  bit brd;                 // model running disparity, 1 = positive
  int unsigned seed = 32'h1234_5678;

  always #2 clk = ~clk;    // 250 MHz

  dw_8b10b_decoder dut (
    .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode), .in_vld(in_vld),
    .code_in(code_in), .out_vld(out_vld), .data_out(data_out),
    .ctl_out(ctl_out), .code_err(code_err), .disp_err(disp_err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // reference encoder, tables in transmission order
  function automatic logic [5:0] r6(input int x);
    logic [5:0] t [32];
    t = '{6'b100111,6'b011101,6'b101101,6'b110001,6'b110101,6'b101001,6'b011001,6'b111000,
          6'b111001,6'b100101,6'b010101,6'b110100,6'b001101,6'b101100,6'b011100,6'b010111,
          6'b011011,6'b100011,6'b010011,6'b110010,6'b001011,6'b101010,6'b011010,6'b111010,
          6'b110011,6'b100110,6'b010110,6'b110110,6'b001110,6'b101110,6'b011110,6'b101011};
    return t[x];
  endfunction

  function automatic logic [10:0] ref_enc(input logic [7:0] v, input bit k, input bit rd);
    logic [3:0] dt [8];
    logic [3:0] kt [8];
    logic [5:0] a;
    logic [3:0] b;
    logic [9:0] w, c;
    bit rm;
    int x, y;
    dt = '{4'b1011,4'b1001,4'b0101,4'b1100,4'b1101,4'b1010,4'b0110,4'b1110};
    kt = '{4'b1011,4'b0110,4'b1010,4'b1100,4'b1101,4'b0101,4'b1001,4'b0111};
    x = int'(v[4:0]); y = int'(v[7:5]);
    a = (k && x == 28) ? 6'b001111 : r6(x);
    if (rd && ($countones(a) != 3 || a == 6'b111000)) a = ~a;
    rm = ($countones(a) == 3) ? rd : !rd;
    if (k) b = (x == 28) ? kt[y] : 4'b0111;
    else if (y == 7 && ((!rm && (x == 17 || x == 18 || x == 20)) ||
                        (rm && (x == 11 || x == 13 || x == 14)))) b = 4'b0111;
    else b = dt[y];
    if (rm && (k || $countones(b) != 2 || b == 4'b1100)) b = ~b;
    w = {a, b};
    for (int j = 0; j < 10; j++) c[j] = w[9-j];
    return {($countones(b) == 2) ? rm : !rm, c};
  endfunction

  task automatic xfer(input bit w, input logic [19:0] c);
    @(negedge clk);
    wide_mode = w; code_in = c; in_vld = 1'b1;
    @(posedge clk);
    #1;
    in_vld = 1'b0;
  endtask

  task automatic chk_lane(input string req, input int ln, input logic [7:0] d,
                          input bit k, input bit ce, input bit de);
    chk({req, " data"}, 32'(data_out[ln*8 +: 8]), 32'(d));
    chk({req, " ctl"},  32'(ctl_out[ln]), 32'(k));
    chk({req, " cerr"}, 32'(code_err[ln]), 32'(ce));
    chk({req, " derr"}, 32'(disp_err[ln]), 32'(de));
  endtask

  function automatic logic [7:0] pick_k(input int i);
    logic [7:0] ex [4];
    ex = '{8'hF7, 8'hFB, 8'hFD, 8'hFE};
    return (i < 8) ? 8'(8'h1C + 32 * i) : ex[i-8];
  endfunction

  task automatic t_reset;
    rst_n = 1'b0; in_vld = 1'b0; wide_mode = 1'b0; code_in = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 vld", 32'(out_vld), 0);
    chk("R1 data", 32'(data_out), 0);
    chk("R1 flags", 32'({ctl_out, code_err, disp_err}), 0);
    @(negedge clk); rst_n = 1'b1;
    xfer(1'b0, 20'h0017C);   // K28.5 negative-disparity form, R1 and R3
    chk("R1/R3 vld", 32'(out_vld), 1);
    chk_lane("R1/R3 K28.5", 0, 8'hBC, 1, 0, 0);
    brd = 1'b1;
  endtask

  task automatic t_single_sweep;
    for (int v = 0; v < 256; v++) begin
      logic [10:0] e;
      e = ref_enc(8'(v), 0, brd);
      xfer(1'b0, {10'h3FF, e[9:0]});
      chk_lane("R3/R7 sweep", 0, 8'(v), 0, 0, 0);
      chk("R4 upper", 32'({data_out[15:8], ctl_out[1], code_err[1], disp_err[1]}), 0);
      brd = e[10];
    end
  endtask

  task automatic t_k_single;
    for (int i = 0; i < 12; i++) begin
      logic [10:0] e;
      e = ref_enc(pick_k(i), 1, brd);
      xfer(1'b0, {10'h000, e[9:0]});
      chk_lane("R8 special", 0, pick_k(i), 1, 0, 0);
      brd = e[10];
    end
  endtask

  task automatic t_double;
    for (int n = 0; n < 300; n++) begin
      logic [10:0] e0, e1;
      logic [7:0]  b0, b1;
      bit k0, k1;
      seed = seed * 32'd1103515245 + 32'd12345;
      k0 = seed[20:18] == 3'd0; k1 = seed[23:21] == 3'd0;
      b0 = k0 ? pick_k(int'(seed[27:24]) % 12) : seed[7:0];
      b1 = k1 ? pick_k(int'(seed[31:28]) % 12) : seed[15:8];
      e0 = ref_enc(b0, k0, brd);
      e1 = ref_enc(b1, k1, e0[10]);
      xfer(1'b1, {e1[9:0], e0[9:0]});
      chk_lane("R5/R6 lane0", 0, b0, k0, 0, 0);
      chk_lane("R5/R6/R7 lane1", 1, b1, k1, 0, 0);
      brd = e1[10];
    end
  endtask

  task automatic t_chain_err;
    logic [10:0] e0, e1, e2;
    e0 = ref_enc(8'h03, 0, brd);          // D3.0 flips disparity
    e1 = ref_enc(8'hBC, 1, brd);          // lane 1 built with the stale disparity
    xfer(1'b1, {e1[9:0], e0[9:0]});
    chk_lane("R6/R11 lane0 clean", 0, 8'h03, 0, 0, 0);
    chk_lane("R6/R10 lane1 disp", 1, 8'hBC, 1, 0, 1);
    brd = e1[10];
    e2 = ref_enc(8'h5A, 0, brd);
    xfer(1'b0, {10'h0, e2[9:0]});
    chk_lane("R10 resync", 0, 8'h5A, 0, 0, 0);
    brd = e2[10];
  endtask

  task automatic t_code_err;
    logic [10:0] e1, e2;
    e1 = ref_enc(8'h4A, 0, brd);          // disparity passes through lane 0
    xfer(1'b1, {e1[9:0], 10'h000});
    chk_lane("R9 lane0 invalid", 0, 8'h00, 0, 1, 0);
    chk_lane("R11 lane1 clean", 1, 8'h4A, 0, 0, 0);
    brd = e1[10];
    xfer(1'b0, 20'h003FF);
    chk_lane("R9 single invalid", 0, 8'h00, 0, 1, 0);
    e2 = ref_enc(8'h1C, 1, brd);
    xfer(1'b0, {10'h0, e2[9:0]});
    chk_lane("R9 rd unchanged", 0, 8'h1C, 1, 0, 0);
    brd = e2[10];
  endtask

  task automatic t_disp_single;
    logic [10:0] e, f;
    e = ref_enc(8'hBC, 1, !brd);
    xfer(1'b0, {10'h0, e[9:0]});
    chk_lane("R10 single disp", 0, 8'hBC, 1, 0, 1);
    brd = e[10];
    f = ref_enc(8'h00, 0, brd);
    xfer(1'b0, {10'h0, f[9:0]});
    chk_lane("R10 after resync", 0, 8'h00, 0, 0, 0);
    brd = f[10];
  endtask

  task automatic t_hold;
    logic [10:0] e, f;
    e = ref_enc(8'h07, 0, brd);
    xfer(1'b0, {10'h0, e[9:0]});
    brd = e[10];
    @(negedge clk); code_in = 20'hFFFFF; wide_mode = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R2 vld low", 32'(out_vld), 0);
    chk("R2 data held", 32'(data_out[7:0]), 32'h07);
    chk("R2 flags held", 32'({code_err, disp_err}), 0);
    f = ref_enc(8'hF0, 0, brd);
    xfer(1'b0, {10'h0, f[9:0]});
    chk_lane("R2/R7 rd held", 0, 8'hF0, 0, 0, 0);
    brd = f[10];
  endtask

  initial begin
    #400000;
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset;
    t_single_sweep;
    t_k_single;
    t_double;
    t_chain_err;
    t_code_err;
    t_disp_single;
    t_hold;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule